// File: doc/BRIEF.md
# Seven-Slot LVDS Pixel Lane Mapper and Serializer

This block turns one parallel video pixel into the serial bit streams of a flat-panel LVDS link. Each pixel carries red, green and blue components of eight bits each, plus horizontal sync, vertical sync and data enable. The block spreads these bits over three or four data lanes, seven bit slots per lane per pixel. It shifts them out one slot per fast-clock tick, which runs at seven times the pixel rate. A separate clock lane carries the forwarded pixel-clock pattern. The differential pads, the PLL and the DDR output stage are outside the block.

Two run-time inputs select the mapping. The first picks one of three formats: an 18-bit three-lane format and two 24-bit four-lane formats that are not compatible with each other. The second reverses the slot order on every data lane. Pixel, format and mirror are all sampled once per pixel period, on the tick that starts it. A slot-0 strobe marks that tick, so downstream logic or a bench can frame each pixel.

Top module: `lvds_pix_serializer`

## Requirements
- R1: Each pixel period lasts exactly 7 fast-clock ticks. With mirror low, each data lane sends its slots in the order 0,1,...,6, one per tick.
- R2: In the 18-bit format (fmt_sel = 0), the six most significant bits of each colour are sent. In slot order 0..6, lane 0 sends G2,R7,R6,R5,R4,R3,R2. Lane 1 sends B3,B2,G7,G6,G5,G4,G3. Lane 2 sends DE,VS,HS,B7,B6,B5,B4.
- R3: In the first 24-bit format (fmt_sel = 1), lanes 0 to 2 are the same as in R2. Lane 3 sends 0,B1,B0,G1,G0,R1,R0 in slot order 0..6.
- R4: In the second 24-bit format (fmt_sel = 2), lanes 0 to 2 use the layout of R2 filled with colour bits 5..0: lane 0 sends G0,R5,R4,R3,R2,R1,R0. Lane 3 sends 0,B7,B6,G7,G6,R7,R6.
- R5: The control bits occupy the first three slots of lane 2, in the order data enable, vertical sync, horizontal sync. Slot 0 of lane 3 is always 0.
- R6: With mirror high, every data lane sends its slots in the order 6,5,...,0.
- R7: In every pixel period after reset, the clock lane sends 1,1,0,0,0,1,1 on ticks 0 to 6.
- R8: lane_count reads 3 in the 18-bit format and 4 in both 24-bit formats. Lane 3 stays 0 while lane_count is 3.
- R9: Pixel, format and mirror are captured only at the start of a pixel period. Changes made during a period do not alter the bits sent in that period.
- R10: Synchronous reset restarts the slot counter. While reset is held, all data lanes, the clock lane and the strobe are 0, and lane_count is 3. On the first tick after reset is released, a new pixel period starts.
- R11: slot0_strb is high on tick 0 of every pixel period and low on the other six ticks.
- R12: The reserved format code (fmt_sel = 3) behaves exactly like the 18-bit format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast serial clock, seven ticks per pixel |
| rst | input | 1 | Synchronous reset, active high |
| pix_r | input | 8 | Red component |
| pix_g | input | 8 | Green component |
| pix_b | input | 8 | Blue component |
| pix_hs | input | 1 | Horizontal sync |
| pix_vs | input | 1 | Vertical sync |
| pix_de | input | 1 | Data enable |
| fmt_sel | input | 2 | Mapping format: 0 18-bit, 1 first 24-bit, 2 second 24-bit, 3 as 0 |
| mirror | input | 1 | Reverse slot order on all data lanes |
| lane_out | output | 4 | Serial data lanes, one bit per tick |
| clk_lane | output | 1 | Forwarded clock pattern lane |
| slot0_strb | output | 1 | High on the first tick of each pixel period |
| lane_count | output | 3 | Number of active data lanes (3 or 4) |

## Verification
The embedded properties check the per-tick invariants on every cycle:
- The slot counter stays in range.
- The strobe never appears on two adjacent ticks, and it coincides with a high clock-lane bit.
- Lane 3 is idle whenever three lanes are reported, and its first slot is zero.
- Format and mirror hold between pixel boundaries.
- The first bit after a load is slot 0, or slot 6 under mirror.
- Data lanes are quiet after a reset tick.

Only the bench scenarios can show that whole words land in the right slots for each format and mirror setting. They also show that the reserved code aliases the 18-bit layout, and that a change of inputs in mid-pixel is deferred to the next period.

// File: rtl/lvdsm_pkg.sv
package lvdsm_pkg;

   // mapping format codes as seen on fmt_sel
   typedef enum logic [1:0] {
      FMT_N18  = 2'd0,
      FMT_W24A = 2'd1,
      FMT_W24B = 2'd2,
      FMT_RSV  = 2'd3
   } fmt_e;

   // clock lane bits for slots 0..6, bit k is slot k
   localparam logic [6:0] CLK_PATTERN = 7'b1100011;

   function automatic logic is_wide(input fmt_e f);
      return (f == FMT_W24A) || (f == FMT_W24B);
   endfunction

endpackage

// File: rtl/lvdsm_slot_timer.sv
module lvdsm_slot_timer #(
   parameter int unsigned SLOTS = 7,
   parameter logic [SLOTS-1:0] PATTERN = lvdsm_pkg::CLK_PATTERN
) (
   input  logic clk,
   input  logic rst,
   output logic load,
   output logic strb,
   output logic clk_bit
);
   localparam int unsigned CW = $clog2(SLOTS);
   localparam logic [CW-1:0] LAST = CW'(SLOTS - 1);

   logic [CW-1:0] cnt;

   generate
      if (SLOTS < 2) begin : g_bad_slots
         $error("lvdsm_slot_timer: SLOTS must be at least 2");
      end
   endgenerate

   assign load = (cnt == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt     <= '0;
         strb    <= 1'b0;
         clk_bit <= 1'b0;
      end else begin
         cnt     <= (cnt == LAST) ? '0 : cnt + 1'b1;
         strb    <= load;
         clk_bit <= PATTERN[cnt];
      end
   end

   // R1
   cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
      cnt <= LAST);

   // R11
   strb_gap_chk: assert property (@(posedge clk) disable iff (rst)
      strb |=> !strb);

   // R7
   clk_head_chk: assert property (@(posedge clk) disable iff (rst)
      strb |-> clk_bit);

endmodule

// File: rtl/lvdsm_lane_map.sv
module lvdsm_lane_map #(
   parameter int unsigned COLOR_W = 8,
   parameter int unsigned SLOTS   = 7,
   parameter int unsigned LANES   = 4
) (
   input  logic [COLOR_W-1:0] r,
   input  logic [COLOR_W-1:0] g,
   input  logic [COLOR_W-1:0] b,
   input  logic               hs,
   input  logic               vs,
   input  logic               de,
   input  lvdsm_pkg::fmt_e    fmt,
   output logic [SLOTS-1:0]   word [LANES]
);
   import lvdsm_pkg::*;

   localparam int unsigned NARROW = 6;

   generate
      if (COLOR_W != 8) begin : g_bad_color
         $error("lvdsm_lane_map: COLOR_W must be 8");
      end
      if (SLOTS != 7) begin : g_bad_slots
         $error("lvdsm_lane_map: SLOTS must be 7");
      end
      if (LANES != 4) begin : g_bad_lanes
         $error("lvdsm_lane_map: LANES must be 4");
      end
   endgenerate

   logic [NARROW-1:0] rn, gn, bn;

   // six-bit view of each colour: low bits for the second wide format,
   // high bits otherwise
   always_comb begin
      if (fmt == FMT_W24B) begin
         rn = r[NARROW-1:0];
         gn = g[NARROW-1:0];
         bn = b[NARROW-1:0];
      end else begin
         rn = r[COLOR_W-1 -: NARROW];
         gn = g[COLOR_W-1 -: NARROW];
         bn = b[COLOR_W-1 -: NARROW];
      end
   end

   // word bit k is slot k
   always_comb begin
      word[0] = {rn[0], rn[1], rn[2], rn[3], rn[4], rn[5], gn[0]};
      word[1] = {gn[1], gn[2], gn[3], gn[4], gn[5], bn[0], bn[1]};
      word[2] = {bn[2], bn[3], bn[4], bn[5], hs, vs, de};
      unique case (fmt)
         FMT_W24A: word[3] = {r[0], r[1], g[0], g[1], b[0], b[1], 1'b0};
         FMT_W24B: word[3] = {r[6], r[7], g[6], g[7], b[6], b[7], 1'b0};
         default:  word[3] = '0;
      endcase
   end

endmodule

// File: rtl/lvdsm_lane_ser.sv
module lvdsm_lane_ser #(
   parameter int unsigned SLOTS = 7
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic             mirror,
   input  logic [SLOTS-1:0] word,
   output logic             bit_o
);
   logic [SLOTS-1:0] rev;
   logic [SLOTS-1:0] sh;

   generate
      for (genvar i = 0; i < SLOTS; i++) begin : g_rev
         assign rev[i] = word[SLOTS-1-i];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         sh <= '0;
      end else if (load) begin
         sh <= mirror ? rev : word;
      end else begin
         sh <= {1'b0, sh[SLOTS-1:1]};
      end
   end

   assign bit_o = sh[0];

   // R1
   first_slot_chk: assert property (@(posedge clk) disable iff (rst)
      (load && !mirror) |=> (bit_o == $past(word[0])));

   // R6
   mirror_first_chk: assert property (@(posedge clk) disable iff (rst)
      (load && mirror) |=> (bit_o == $past(word[SLOTS-1])));

endmodule

// File: rtl/lvds_pix_serializer.sv
module lvds_pix_serializer #(
   parameter int unsigned COLOR_W = 8,
   parameter int unsigned SLOTS   = 7,
   parameter int unsigned LANES   = 4
) (
   input  logic                            clk,
   input  logic                            rst,
   input  logic [COLOR_W-1:0]              pix_r,
   input  logic [COLOR_W-1:0]              pix_g,
   input  logic [COLOR_W-1:0]              pix_b,
   input  logic                            pix_hs,
   input  logic                            pix_vs,
   input  logic                            pix_de,
   input  logic [1:0]                      fmt_sel,
   input  logic                            mirror,
   output logic [LANES-1:0]                lane_out,
   output logic                            clk_lane,
   output logic                            slot0_strb,
   output logic [$clog2(LANES+1)-1:0]      lane_count
);
   import lvdsm_pkg::*;

   localparam int unsigned LCW = $clog2(LANES + 1);

   logic             load;
   logic [SLOTS-1:0] word [LANES];
   fmt_e             fmt_in;
   fmt_e             fmt_q;
   logic             mir_q;

   assign fmt_in = fmt_e'(fmt_sel);

   lvdsm_slot_timer #(
      .SLOTS   (SLOTS),
      .PATTERN (CLK_PATTERN)
   ) i_timer (
      .clk     (clk),
      .rst     (rst),
      .load    (load),
      .strb    (slot0_strb),
      .clk_bit (clk_lane)
   );

   lvdsm_lane_map #(
      .COLOR_W (COLOR_W),
      .SLOTS   (SLOTS),
      .LANES   (LANES)
   ) i_map (
      .r    (pix_r),
      .g    (pix_g),
      .b    (pix_b),
      .hs   (pix_hs),
      .vs   (pix_vs),
      .de   (pix_de),
      .fmt  (fmt_in),
      .word (word)
   );

   generate
      for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
         lvdsm_lane_ser #(
            .SLOTS (SLOTS)
         ) i_ser (
            .clk    (clk),
            .rst    (rst),
            .load   (load),
            .mirror (mirror),
            .word   (word[ln]),
            .bit_o  (lane_out[ln])
         );
      end
   endgenerate

   // format and mirror of the pixel being sent
   always_ff @(posedge clk) begin
      if (rst) begin
         fmt_q <= FMT_N18;
         mir_q <= 1'b0;
      end else if (load) begin
         fmt_q <= fmt_in;
         mir_q <= mirror;
      end
   end

   assign lane_count = is_wide(fmt_q) ? LCW'(LANES) : LCW'(LANES - 1);

   // R8
   lane3_idle_chk: assert property (@(posedge clk) disable iff (rst)
      (lane_count == LCW'(LANES - 1)) |-> !lane_out[LANES-1]);

   // R5
   ctl3_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (slot0_strb && !mir_q) |-> !lane_out[LANES-1]);

   // R9
   cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !load |=> ($stable(fmt_q) && $stable(mir_q)));

   // R10
   rst_quiet_chk: assert property (@(posedge clk)
      rst |=> (lane_out == '0));

endmodule

// File: tb/test_lvds_pix_serializer.sv
`timescale 1ns/1ps
module test_lvds_pix_serializer;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] pix_r = '0, pix_g = '0, pix_b = '0;
   logic       pix_hs = 1'b0, pix_vs = 1'b0, pix_de = 1'b0;
   logic [1:0] fmt_sel = '0;
   logic       mirror = 1'b0;
   logic [3:0] lane_out;
   logic       clk_lane, slot0_strb;
   logic [2:0] lane_count;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   lvds_pix_serializer i_lvds_pix_serializer (
      .clk (clk), .rst (rst),
      .pix_r (pix_r), .pix_g (pix_g), .pix_b (pix_b),
      .pix_hs (pix_hs), .pix_vs (pix_vs), .pix_de (pix_de),
      .fmt_sel (fmt_sel), .mirror (mirror),
      .lane_out (lane_out), .clk_lane (clk_lane),
      .slot0_strb (slot0_strb), .lane_count (lane_count)
   );

   // {fmt[29:28], mirror[27], r[26:19], g[18:11], b[10:3], hs, vs, de}
   localparam int NV = 9;
   localparam logic [29:0] VEC [NV] = '{
      {2'd0, 1'b0, 8'hA5, 8'h3C, 8'hF0, 1'b1, 1'b0, 1'b1},
      {2'd1, 1'b0, 8'h81, 8'h42, 8'h24, 1'b0, 1'b1, 1'b0},
      {2'd2, 1'b0, 8'hC3, 8'h5A, 8'h96, 1'b1, 1'b1, 1'b1},
      {2'd0, 1'b1, 8'hFF, 8'h00, 8'hAA, 1'b0, 1'b0, 1'b1},
      {2'd1, 1'b1, 8'h12, 8'h34, 8'h56, 1'b1, 1'b0, 1'b0},
      {2'd2, 1'b1, 8'hE7, 8'h18, 8'h7E, 1'b0, 1'b1, 1'b1},
      {2'd3, 1'b0, 8'h6B, 8'hD4, 8'h39, 1'b1, 1'b0, 1'b1},
      {2'd2, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1},
      {2'd1, 1'b0, 8'h03, 8'h03, 8'h03, 1'b0, 1'b0, 1'b0}
   };

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // expected lane word, bit k is slot k
   function automatic logic [6:0] exp_word(input logic [1:0] f, input logic [7:0] r,
      input logic [7:0] g, input logic [7:0] b, input logic hs, input logic vs,
      input logic de, input int lane);
      logic [6:0] w;
      logic [7:0] rr, gg, bb;
      w = '0;
      if (f == 2'd2) begin
         rr = {r[5:0], 2'b00}; gg = {g[5:0], 2'b00}; bb = {b[5:0], 2'b00};
      end else begin
         rr = r; gg = g; bb = b;
      end
      case (lane)
         0: begin w[0]=gg[2]; w[1]=rr[7]; w[2]=rr[6]; w[3]=rr[5]; w[4]=rr[4]; w[5]=rr[3]; w[6]=rr[2]; end
         1: begin w[0]=bb[3]; w[1]=bb[2]; w[2]=gg[7]; w[3]=gg[6]; w[4]=gg[5]; w[5]=gg[4]; w[6]=gg[3]; end
         2: begin w[0]=de; w[1]=vs; w[2]=hs; w[3]=bb[7]; w[4]=bb[6]; w[5]=bb[5]; w[6]=bb[4]; end
         default: begin
            if (f == 2'd1) begin
               w[1]=b[1]; w[2]=b[0]; w[3]=g[1]; w[4]=g[0]; w[5]=r[1]; w[6]=r[0];
            end else if (f == 2'd2) begin
               w[1]=b[7]; w[2]=b[6]; w[3]=g[7]; w[4]=g[6]; w[5]=r[7]; w[6]=r[6];
            end
         end
      endcase
      return w;
   endfunction

   task automatic apply(input logic [29:0] v);
      fmt_sel = v[29:28]; mirror = v[27];
      pix_r = v[26:19]; pix_g = v[18:11]; pix_b = v[10:3];
      pix_hs = v[2]; pix_vs = v[1]; pix_de = v[0];
   endtask

   // send one pixel and check one full period; scramble changes inputs on tick 0
   task automatic run_vec(input logic [29:0] v, input bit scramble);
      logic [6:0] got [4];
      logic [6:0] gclk, gstb;
      logic [6:0] e, et;
      logic [2:0] cnt_seen;
      string tag;
      do @(negedge clk); while (!slot0_strb);
      apply(v);
      repeat (7) @(negedge clk);
      cnt_seen = lane_count;
      for (int t = 0; t < 7; t++) begin
         for (int ln = 0; ln < 4; ln++) got[ln][t] = lane_out[ln];
         gclk[t] = clk_lane;
         gstb[t] = slot0_strb;
         if (t == 0 && scramble) apply(~v);
         if (t < 6) @(negedge clk);
      end
      case (v[29:28])
         2'd1: tag = "R3";
         2'd2: tag = "R4";
         2'd3: tag = "R12";
         default: tag = "R2";
      endcase
      if (v[27]) tag = {tag, "/R6"};
      if (scramble) tag = {tag, "/R9"};
      for (int ln = 0; ln < 4; ln++) begin
         e = exp_word(v[29:28], v[26:19], v[18:11], v[10:3], v[2], v[1], v[0], ln);
         for (int t = 0; t < 7; t++) et[t] = v[27] ? e[6-t] : e[t];
         chk(got[ln] == et, (ln == 2) ? {tag, "/R5"} : tag,
             $sformatf("lane%0d ticks", ln), 32'(got[ln]), 32'(et));
      end
      // R7 clock lane pattern, R11 strobe only on tick 0, R1 period length
      chk(gclk == 7'b1100011, "R7", "clock lane ticks", 32'(gclk), 32'h63);
      chk(gstb == 7'b0000001, "R11/R1", "strobe ticks", 32'(gstb), 32'h01);
      // R8 lane count
      chk(cnt_seen == ((v[29:28] == 2'd1 || v[29:28] == 2'd2) ? 3'd4 : 3'd3),
          "R8", "lane_count", 32'(cnt_seen),
          (v[29:28] == 2'd1 || v[29:28] == 2'd2) ? 32'd4 : 32'd3);
   endtask

   initial begin
      #(8 * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      // R10: inputs busy while reset is held
      apply({2'd1, 1'b0, 8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b1});
      repeat (4) @(negedge clk);
      chk(lane_out == 4'h0, "R10", "lanes in reset", 32'(lane_out), 0);
      chk(slot0_strb == 1'b0 && clk_lane == 1'b0, "R10", "strobe/clk in reset",
          {30'd0, slot0_strb, clk_lane}, 0);
      chk(lane_count == 3'd3, "R10", "lane_count in reset", 32'(lane_count), 3);
      rst = 1'b0;
      @(negedge clk);
      chk(slot0_strb == 1'b1, "R10/R11", "first tick after reset", 32'(slot0_strb), 1);

      // vector table
      for (int i = 0; i < NV; i++) run_vec(VEC[i], 1'b0);

      // R9: mid-pixel change of every input
      run_vec(VEC[1], 1'b1);
      run_vec(VEC[5], 1'b1);

      // R10: reset in mid-period restarts the slot counter
      apply(VEC[0]);
      do @(negedge clk); while (!slot0_strb);
      repeat (3) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk(lane_out == 4'h0, "R10", "lanes after mid-run reset", 32'(lane_out), 0);
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk(slot0_strb == 1'b1, "R10", "restart strobe", 32'(slot0_strb), 1);
      // lane 2 slot 0 carries DE=1 of VEC[0] in the restarted period
      chk(lane_out[2] == 1'b1, "R10/R5", "restarted lane2 slot0", 32'(lane_out[2]), 1);
      run_vec(VEC[2], 1'b0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule